// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a physical address by reading a three-level page table from memory. The caller presents a virtual address, the access kind, the effective privilege, two status controls (make-executable-readable and supervisor-may-touch-user-pages) and the physical page number of the root table. The walker then issues 8-byte entry reads over a request/response memory port. Each level consumes one 9-bit slice of the virtual page number, and the page offset is 12 bits.

At a leaf the walker checks the entry's permissions and the alignment of a superpage. When the access requires the accessed or dirty flag to be set, it writes the updated entry back to memory before it reports the result. The result carries the physical address, the final leaf entry, the entry's address, the leaf level and a global flag gathered along the path. A failure carries an error code instead. The walker holds no translation cache of its own.

Top module: `sv39_ptw`

## Requirements
- R1: After reset `busy_o`, `done_o` and `mem_req_o` are 0.
- R2: The walk starts at level 2 with base = `root_ppn_i`. The entry address at level L is base*4096 + vaddr[12+9L +: 9]*8. A pointer entry has V=1 and R=W=X=0; it sets the next base to its PPN (bits 53:10) and lowers the level by one.
- R3: Entry flag positions are V=bit0, R=1, W=2, X=3, U=4, G=5, A=6, D=7. An entry with V=0, or with W=1 and R=0, ends the walk with error code 1.
- R4: A pointer entry read at level 0 ends the walk with error code 1.
- R5: Access codes are 0=read, 1=write, 2=execute. For a user access the leaf needs U=1 and the access right: R or (X and mxr) to read, W to write, X to execute. For a supervisor read or write the leaf needs U=0 or sum=1, and the right. For a supervisor execute the leaf needs U=0 and X. A failed check returns error code 2.
- R6: A leaf at level 1 or 2 is a superpage. If the low 9*level bits of its PPN are nonzero, the walk returns error code 3.
- R7: On success `err_o`=0, `ok_o`=1 and `level_o` is the leaf level. `pa_o` is the leaf PPN with its low 9*level bits taken from the virtual page number, followed by the 12-bit offset.
- R8: `global_o` is 1 when any entry on the path, the leaf included, has G=1.
- R9: An update is needed when A=0, or when the access is a write and D=0. The walker then writes the entry with A set (and D set for a write) to the entry address. `pte_o` returns that updated entry. When no update is needed, nothing is written.
- R10: An error on a read response or on the write-back response returns error code 4.
- R11: With `AD_UPDATE_EN`=0, a leaf that needs an update returns error code 5 and no write is issued.
- R12: `req_valid_i` is sampled only while idle. `done_o` is a one-cycle pulse. A walk of n reads with zero-wait responses raises `done_o` 1+2n cycles after the accepting edge, plus one cycle when a write-back occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Start a walk (sampled while idle) |
| req_vaddr_i | input | 39 | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user_i | input | 1 | Effective privilege is user |
| mxr_i | input | 1 | Executable pages readable |
| sum_i | input | 1 | Supervisor may access user pages |
| root_ppn_i | input | 44 | Root table physical page number |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Result valid pulse |
| ok_o | output | 1 | Result is a translation |
| err_o | output | 3 | Error code, 0 on success |
| pa_o | output | 56 | Physical address |
| pte_o | output | 64 | Leaf entry as written back or read |
| pte_addr_o | output | 56 | Address of the leaf entry |
| level_o | output | 2 | Leaf level |
| global_o | output | 1 | Accumulated global flag |
| mem_req_o | output | 1 | Memory request, held until response |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 56 | Entry address |
| mem_wdata_o | output | 64 | Write data |
| mem_rsp_i | input | 1 | Memory response valid |
| mem_rdata_i | input | 64 | Read data |
| mem_err_i | input | 1 | Response error |

## Verification
The result is due a fixed number of cycles after the request edge. Each read costs two cycles (one waiting for the response, one deciding) and a write-back adds one, so a gigapage hit lands after 3 cycles, a three-level walk after 7 and a read fault after 2. The bench's memory model answers in the same cycle a request appears. The bench then counts cycles from the accepting edge until `done_o` and compares that count with the expected one. It samples every result field on the falling edge of that cycle and confirms that `done_o` has dropped one cycle later.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 39;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 9;
  localparam int LEVELS = 3;
  localparam int PPN_W  = 44;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int PTE_W  = 64;
  localparam int LVL_W  = $clog2(LEVELS);

  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int B_U = 4;
  localparam int B_G = 5;
  localparam int B_A = 6;
  localparam int B_D = 7;
  localparam int PPN_LSB = 10;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2} acc_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_INVALID  = 3'd1,
    ERR_PERM     = 3'd2,
    ERR_MISALIGN = 3'd3,
    ERR_ACCESS   = 3'd4,
    ERR_UPDATE   = 3'd5
  } walk_err_e;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_EVAL, S_WB, S_DONE} walk_st_e;
endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  logic [1:0]       acc_i,
  input  logic             user_i,
  input  logic             mxr_i,
  input  logic             sum_i,
  output logic             inv_o,
  output logic             ptr_o,
  output logic             leaf_o,
  output logic             perm_ok_o,
  output logic             need_upd_o,
  output logic [PTE_W-1:0] upd_pte_o
);
  logic v, r, w, x, u, a, d;
  logic is_wr, is_ex, rights;

  assign v = pte_i[B_V];
  assign r = pte_i[B_R];
  assign w = pte_i[B_W];
  assign x = pte_i[B_X];
  assign u = pte_i[B_U];
  assign a = pte_i[B_A];
  assign d = pte_i[B_D];

  assign is_wr = (acc_i == ACC_WRITE);
  assign is_ex = (acc_i != ACC_READ) && !is_wr;

  assign inv_o  = !v || (w && !r);
  assign ptr_o  = !inv_o && !r && !x;
  assign leaf_o = !inv_o && (r || x);

  always_comb begin
    if (is_wr)      rights = w;
    else if (is_ex) rights = x;
    else            rights = r || (x && mxr_i);
  end

  always_comb begin
    if (user_i)     perm_ok_o = u && rights;
    else if (is_ex) perm_ok_o = !u && x;
    else            perm_ok_o = (!u || sum_i) && rights;
  end

  assign need_upd_o = !a || (is_wr && !d);

  always_comb begin
    upd_pte_o = pte_i;
    upd_pte_o[B_A] = 1'b1;
    if (is_wr) upd_pte_o[B_D] = 1'b1;
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [PPN_W-1:0] base_ppn_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [PPN_W-1:0] leaf_ppn_i,
  output logic [PA_W-1:0]  pte_addr_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             misalign_o
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int SLOT_LG = OFF_W - IDX_W;

  logic [IDX_W-1:0] idx_tbl [LEVELS];
  logic [IDX_W-1:0] idx;
  logic [PPN_W-1:0] mask;
  logic [PPN_W-1:0] vpn_ext;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_tbl[g] = vaddr_i[OFF_W + IDX_W*g +: IDX_W];
  end

  always_comb begin
    idx  = '0;
    mask = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (lvl_i == LVL_W'(l)) begin
        idx  = idx_tbl[l];
        mask = (PPN_W'(1) << (IDX_W*l)) - PPN_W'(1);
      end
    end
  end

  assign vpn_ext    = PPN_W'(vaddr_i[VA_W-1:OFF_W]);
  assign pte_addr_o = {base_ppn_i, idx, {SLOT_LG{1'b0}}};
  assign pa_o       = {(leaf_ppn_i & ~mask) | (vpn_ext & mask), vaddr_i[OFF_W-1:0]};
  assign misalign_o = |(leaf_ppn_i & mask);
endmodule

// File: rtl/sv39_ptw.sv
module sv39_ptw
  import ptw_pkg::*;
#(
  parameter bit AD_UPDATE_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [1:0]       req_acc_i,
  input  logic             req_user_i,
  input  logic             mxr_i,
  input  logic             sum_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ok_o,
  output logic [2:0]       err_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [PTE_W-1:0] pte_o,
  output logic [PA_W-1:0]  pte_addr_o,
  output logic [LVL_W-1:0] level_o,
  output logic             global_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic             mem_rsp_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  input  logic             mem_err_i
);
  walk_st_e         st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PPN_W-1:0] base_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             user_q, mxr_q, sum_q;
  logic [PTE_W-1:0] pte_q;
  logic             g_q;
  walk_err_e        err_q;
  logic [PA_W-1:0]  pa_q, pte_addr_q;

  logic             inv, ptr, leaf, perm_ok, need_upd, misalign;
  logic [PTE_W-1:0] upd_pte;
  logic [PA_W-1:0]  cur_addr, leaf_pa;
  logic             g_next;

  ptw_pte_decode u_dec (
    .pte_i      (pte_q),
    .acc_i      (acc_q),
    .user_i     (user_q),
    .mxr_i      (mxr_q),
    .sum_i      (sum_q),
    .inv_o      (inv),
    .ptr_o      (ptr),
    .leaf_o     (leaf),
    .perm_ok_o  (perm_ok),
    .need_upd_o (need_upd),
    .upd_pte_o  (upd_pte)
  );

  ptw_addr_gen u_addr (
    .base_ppn_i (base_q),
    .vaddr_i    (va_q),
    .lvl_i      (lvl_q),
    .leaf_ppn_i (pte_q[PPN_LSB +: PPN_W]),
    .pte_addr_o (cur_addr),
    .pa_o       (leaf_pa),
    .misalign_o (misalign)
  );

  assign g_next = g_q | pte_q[B_G];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      lvl_q      <= '0;
      base_q     <= '0;
      va_q       <= '0;
      acc_q      <= '0;
      user_q     <= 1'b0;
      mxr_q      <= 1'b0;
      sum_q      <= 1'b0;
      pte_q      <= '0;
      g_q        <= 1'b0;
      err_q      <= ERR_NONE;
      pa_q       <= '0;
      pte_addr_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          st_q   <= S_RD;
          lvl_q  <= LVL_W'(LEVELS-1);
          base_q <= root_ppn_i;
          va_q   <= req_vaddr_i;
          acc_q  <= req_acc_i;
          user_q <= req_user_i;
          mxr_q  <= mxr_i;
          sum_q  <= sum_i;
          g_q    <= 1'b0;
          err_q  <= ERR_NONE;
        end
        S_RD: if (mem_rsp_i) begin
          if (mem_err_i) begin
            err_q <= ERR_ACCESS;
            st_q  <= S_DONE;
          end else begin
            pte_q <= mem_rdata_i;
            st_q  <= S_EVAL;
          end
        end
        S_EVAL: begin
          g_q        <= g_next;
          pte_addr_q <= cur_addr;
          st_q       <= S_DONE;
          if (inv) begin
            err_q <= ERR_INVALID;
          end else if (ptr) begin
            if (lvl_q == '0) begin
              err_q <= ERR_INVALID;
            end else begin
              base_q <= pte_q[PPN_LSB +: PPN_W];
              lvl_q  <= lvl_q - 1'b1;
              st_q   <= S_RD;
            end
          end else if (!perm_ok) begin
            err_q <= ERR_PERM;
          end else if (misalign) begin
            err_q <= ERR_MISALIGN;
          end else begin
            pa_q <= leaf_pa;
            if (need_upd) begin
              if (AD_UPDATE_EN) begin
                pte_q <= upd_pte;
                st_q  <= S_WB;
              end else begin
                err_q <= ERR_UPDATE;
              end
            end
          end
        end
        S_WB: if (mem_rsp_i) begin
          if (mem_err_i) err_q <= ERR_ACCESS;
          st_q <= S_DONE;
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_DONE);
  assign ok_o        = (err_q == ERR_NONE);
  assign err_o       = err_q;
  assign pa_o        = pa_q;
  assign pte_o       = pte_q;
  assign pte_addr_o  = pte_addr_q;
  assign level_o     = lvl_q;
  assign global_o    = g_q;
  assign mem_req_o   = (st_q == S_RD) || (st_q == S_WB);
  assign mem_we_o    = (st_q == S_WB);
  assign mem_addr_o  = cur_addr;
  assign mem_wdata_o = pte_q;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !done_o));

  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_wb_sets_a_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[B_A] && mem_wdata_o[B_V]));

  assert_no_wb_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (AD_UPDATE_EN || !mem_we_o));

  assert_done_no_req_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);
endmodule

// File: tb/sv39_ptw_tb_top.sv
module sv39_ptw_tb_top;
  import ptw_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [43:0] ROOT = 44'h100;
  localparam logic [43:0] GPPN = 44'h40000;
  localparam logic [38:0] VA_G = {9'd3, 9'h15, 9'h0AB, 12'h123};
  localparam int NVEC = 14;
  // {flags, acc, user, mxr, sum, expected err}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'hC7, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
    {8'h47, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0},
    {8'h07, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
    {8'hC3, 2'd1, 1'b0, 1'b0, 1'b0, 3'd2},
    {8'hC9, 2'd0, 1'b0, 1'b0, 1'b0, 3'd2},
    {8'hC9, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0},
    {8'hD3, 2'd0, 1'b0, 1'b0, 1'b0, 3'd2},
    {8'hD3, 2'd0, 1'b0, 1'b0, 1'b1, 3'd0},
    {8'hD9, 2'd2, 1'b0, 1'b0, 1'b1, 3'd2},
    {8'hD9, 2'd2, 1'b1, 1'b0, 1'b0, 3'd0},
    {8'hC3, 2'd0, 1'b1, 1'b0, 1'b0, 3'd2},
    {8'hC5, 2'd0, 1'b0, 1'b0, 1'b0, 3'd1},
    {8'hC6, 2'd0, 1'b0, 1'b0, 1'b0, 3'd1},
    {8'hCF, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [38:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0, mxr = 1'b0, sum = 1'b0;
  logic [43:0] root = ROOT;
  logic        busy, done, ok, glob;
  logic [2:0]  err;
  logic [55:0] pa, pte_addr, mem_addr;
  logic [63:0] pte, mem_wdata;
  logic [1:0]  level;
  logic        mem_req, mem_we;
  logic        mem_rsp = 1'b0, mem_err = 1'b0;
  logic [63:0] mem_rdata = '0;

  logic        n_req_valid = 1'b0;
  logic        n_busy, n_done, n_ok, n_glob, n_mem_req, n_mem_we;
  logic [2:0]  n_err;
  logic [55:0] n_pa, n_pte_addr, n_mem_addr;
  logic [63:0] n_pte, n_mem_wdata;
  logic [1:0]  n_level;
  logic        n_mem_rsp = 1'b0;
  int          n_wr_cnt = 0;

  logic [55:0] m_addr [16];
  logic [63:0] m_data [16];
  int          m_n = 0;
  logic        flt_rd = 1'b0, flt_wr = 1'b0;
  logic [55:0] flt_addr = '0;
  int          wr_cnt = 0;
  logic [55:0] wr_addr = '0;
  logic [63:0] wr_data = '0;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sv39_ptw #(.AD_UPDATE_EN(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_va),
    .req_acc_i(req_acc), .req_user_i(req_user), .mxr_i(mxr), .sum_i(sum),
    .root_ppn_i(root), .busy_o(busy), .done_o(done), .ok_o(ok), .err_o(err),
    .pa_o(pa), .pte_o(pte), .pte_addr_o(pte_addr), .level_o(level), .global_o(glob),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rsp_i(mem_rsp), .mem_rdata_i(mem_rdata),
    .mem_err_i(mem_err)
  );

  sv39_ptw #(.AD_UPDATE_EN(1'b0)) dut_noad_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(n_req_valid), .req_vaddr_i(VA_G),
    .req_acc_i(2'd1), .req_user_i(1'b0), .mxr_i(1'b0), .sum_i(1'b0),
    .root_ppn_i(ROOT), .busy_o(n_busy), .done_o(n_done), .ok_o(n_ok), .err_o(n_err),
    .pa_o(n_pa), .pte_o(n_pte), .pte_addr_o(n_pte_addr), .level_o(n_level),
    .global_o(n_glob), .mem_req_o(n_mem_req), .mem_we_o(n_mem_we),
    .mem_addr_o(n_mem_addr), .mem_wdata_o(n_mem_wdata), .mem_rsp_i(n_mem_rsp),
    .mem_rdata_i({GPPN, 10'h007}), .mem_err_i(1'b0)
  );

  function automatic logic [63:0] mem_get(input logic [55:0] a);
    for (int i = 0; i < m_n; i++) if (m_addr[i] == a) return m_data[i];
    return 64'h0;
  endfunction

  task automatic mem_set(input logic [55:0] a, input logic [63:0] d);
    for (int i = 0; i < m_n; i++) if (m_addr[i] == a) begin m_data[i] = d; return; end
    m_addr[m_n] = a;
    m_data[m_n] = d;
    m_n++;
  endtask

  // zero-wait memory: answers in the cycle the request is seen
  always @(negedge clk) begin
    mem_rsp   = mem_req;
    mem_rdata = mem_get(mem_addr);
    mem_err   = mem_req && (mem_addr == flt_addr) && (mem_we ? flt_wr : flt_rd);
    if (mem_req && mem_we) begin
      wr_cnt++;
      wr_addr = mem_addr;
      wr_data = mem_wdata;
      if (!mem_err) mem_set(mem_addr, mem_wdata);
    end
    n_mem_rsp = n_mem_req;
    if (n_mem_req && n_mem_we) n_wr_cnt++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [38:0] va, input logic [1:0] acc, input logic usr,
                      input logic mx, input logic sm, output int lat);
    @(negedge clk);
    req_va = va; req_acc = acc; req_user = usr; mxr = mx; sum = sm;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic logic [55:0] ent_addr(input logic [43:0] base, input logic [38:0] va, input int l);
    return {base, va[12 + 9*l +: 9], 3'b000};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    logic [7:0]  fl;
    logic [1:0]  acc;
    logic [2:0]  eerr;
    logic        ewb;
    logic [63:0] epte;
    int          w0;
    logic [38:0] va3;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 mem_req", 64'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", 64'({busy, mem_req}), 0);

    // gigapage leaf table: R3 R5 R7 R9 R12
    for (int i = 0; i < NVEC; i++) begin
      fl   = VEC[i][15:8];
      acc  = VEC[i][7:6];
      eerr = VEC[i][2:0];
      ewb  = (eerr == 0) && (!fl[6] || (acc == 2'd1 && !fl[7]));
      mem_set(ent_addr(ROOT, VA_G, 2), {GPPN, 2'b00, fl});
      w0 = wr_cnt;
      walk(VA_G, acc, VEC[i][5], VEC[i][4], VEC[i][3], lat);
      chk($sformatf("R5/R3 err vec%0d", i), 64'(err), 64'(eerr));
      chk($sformatf("R12 latency vec%0d", i), 64'(lat), ewb ? 4 : 3);
      chk($sformatf("R9 write count vec%0d", i), 64'(wr_cnt - w0), ewb ? 1 : 0);
      if (eerr == 0) begin
        epte = {GPPN, 2'b00, fl};
        if (ewb) begin
          epte[6] = 1'b1;
          if (acc == 2'd1) epte[7] = 1'b1;
          chk($sformatf("R9 wb addr vec%0d", i), 64'(wr_addr), 64'(ent_addr(ROOT, VA_G, 2)));
          chk($sformatf("R9 wb data vec%0d", i), wr_data, epte);
        end
        chk($sformatf("R7 ok vec%0d", i), 64'(ok), 1);
        chk($sformatf("R7 pa vec%0d", i), 64'(pa), 64'({GPPN, 12'h0} | 56'(VA_G[29:0])));
        chk($sformatf("R7 level vec%0d", i), 64'(level), 2);
        chk($sformatf("R9 pte vec%0d", i), pte, epte);
        chk($sformatf("R2 pte_addr vec%0d", i), 64'(pte_addr), 64'(ent_addr(ROOT, VA_G, 2)));
        chk($sformatf("R8 global clear vec%0d", i), 64'(glob), 0);
      end
      @(negedge clk);
      chk($sformatf("R12 pulse vec%0d", i), 64'(done), 0);
    end

    // R2 R8 full three-level walk, G only on root pointer
    va3 = {9'd1, 9'd2, 9'd3, 12'h456};
    mem_set(ent_addr(ROOT, va3, 2), {44'h200, 10'h021});
    mem_set(ent_addr(44'h200, va3, 1), {44'h300, 10'h001});
    mem_set(ent_addr(44'h300, va3, 0), {44'h12345, 10'h0C7});
    walk(va3, 2'd0, 1'b0, 1'b0, 1'b0, lat);
    chk("R2 three-level latency", 64'(lat), 7);
    chk("R2 three-level err", 64'(err), 0);
    chk("R7 three-level pa", 64'(pa), 64'({44'h12345, 12'h456}));
    chk("R7 three-level level", 64'(level), 0);
    chk("R2 three-level pte_addr", 64'(pte_addr), 64'(ent_addr(44'h300, va3, 0)));
    chk("R8 sticky global", 64'(glob), 1);

    // R6 R7 aligned megapage at level 1
    mem_set(ent_addr(44'h200, va3, 1), {44'h400, 10'h0C3});
    walk(va3, 2'd0, 1'b0, 1'b0, 1'b0, lat);
    chk("R7 megapage latency", 64'(lat), 5);
    chk("R7 megapage level", 64'(level), 1);
    chk("R7 megapage pa", 64'(pa), 64'({44'h400, 12'h0} | 56'(va3[20:0])));

    // R6 misaligned megapage
    mem_set(ent_addr(44'h200, va3, 1), {44'h401, 10'h0C3});
    walk(va3, 2'd0, 1'b0, 1'b0, 1'b0, lat);
    chk("R6 misaligned err", 64'(err), 3);
    chk("R6 misaligned ok", 64'(ok), 0);

    // R4 pointer at level 0
    mem_set(ent_addr(44'h200, va3, 1), {44'h300, 10'h001});
    mem_set(ent_addr(44'h300, va3, 0), {44'h500, 10'h001});
    walk(va3, 2'd0, 1'b0, 1'b0, 1'b0, lat);
    chk("R4 pointer at level 0 err", 64'(err), 1);
    chk("R4 latency", 64'(lat), 7);

    // R10 read response error on the root entry
    flt_addr = ent_addr(ROOT, va3, 2);
    flt_rd = 1'b1;
    walk(va3, 2'd0, 1'b0, 1'b0, 1'b0, lat);
    chk("R10 read fault err", 64'(err), 4);
    chk("R10 read fault latency", 64'(lat), 2);
    flt_rd = 1'b0;

    // R10 write-back error
    mem_set(ent_addr(ROOT, VA_G, 2), {GPPN, 10'h007});
    flt_addr = ent_addr(ROOT, VA_G, 2);
    flt_wr = 1'b1;
    w0 = wr_cnt;
    walk(VA_G, 2'd0, 1'b0, 1'b0, 1'b0, lat);
    chk("R10 wb fault err", 64'(err), 4);
    chk("R10 wb attempted", 64'(wr_cnt - w0), 1);
    chk("R10 wb fault latency", 64'(lat), 4);
    flt_wr = 1'b0;

    // R11 update disabled instance
    @(negedge clk);
    n_req_valid = 1'b1;
    @(negedge clk);
    n_req_valid = 1'b0;
    lat = 1;
    while (!n_done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    chk("R11 update disabled err", 64'(n_err), 5);
    chk("R11 no write issued", 64'(n_wr_cnt), 0);
    chk("R11 latency", 64'(lat), 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule